// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive by issuing refresh cycles in which the column strobe falls before the row strobe. Because the memory holds its own internal row counter for this kind of cycle, the block drives no address. A programmable interval timer adds one entry to a saturating pending count at each expiry. Whenever the count is non-zero and the neighbouring access controller reports idle, the block takes the strobe lines and runs one refresh cycle.

The write-enable, output-enable and address outputs stay at fixed inactive values the whole time. Write-enable high during the row-strobe fall keeps the memory out of its test mode.

After reset the block first waits a start-up delay with both strobes high. It then runs a fixed number of dummy refresh cycles without asking the access controller. Only after that does it raise `mem_ready`. A select input switches the refresh interval between a standard rate and a slower low-power rate.

Top module: `dref_seq`

## Requirements
- R1: While reset is asserted and right after it, ras_n and cas_n are 1, we_n and oe_n are 1, addr_o is all zeros, and ref_req, ref_busy and mem_ready are 0.
- R2: After reset is released, cas_n and ras_n stay high for at least INIT_WAIT clock cycles. The first cas_n fall comes no later than INIT_WAIT+3 cycles after release.
- R3: After the start-up delay, exactly INIT_CYCLES refresh cycles run regardless of ctrl_idle. mem_ready then rises and never falls again until reset.
- R4: In every refresh cycle cas_n is low for exactly T_CSR cycles before ras_n falls. cas_n stays low for as long as ras_n is low.
- R5: ras_n stays low for exactly T_RAS cycles. Both strobes are then high for at least T_RP cycles before cas_n falls again.
- R6: we_n and oe_n are 1 and addr_o is 0 at every ras_n fall, including the cycle before it.
- R7: Once ready, with ctrl_idle held high, successive ras_n falls are INT_STD cycles apart when lp_sel=0 and INT_LP cycles apart when lp_sel=1.
- R8: A refresh starts only while ctrl_idle is high. ref_req is 1 while at least one refresh is pending.
- R9: The pending count saturates at PEND_MAX. After many missed intervals, exactly PEND_MAX back-to-back refresh cycles run once ctrl_idle returns.
- R10: ref_busy is 1 from the first cas_n-low cycle to the end of precharge. Whenever ref_busy is 0, both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_sel | input | 1 | 1 selects the long (low-power) refresh interval |
| ctrl_idle | input | 1 | Access controller has no cycle in progress |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| oe_n | output | 1 | Output enable, held high |
| addr_o | output | ADDR_W | Address lines, held at zero |
| ref_req | output | 1 | At least one refresh is pending |
| ref_busy | output | 1 | Sequencer owns the strobes |
| mem_ready | output | 1 | Start-up sequence complete |

## Verification
A wrong pending count shows up as a missing or extra burst of back-to-back refresh cycles, as soon as ctrl_idle returns after a long hold-off. A phase error in the strobe state machine appears on the very next cycle as a wrong cas_n lead or a wrong ras_n width, measured edge to edge. A faulty start-up counter moves the first strobe edge or changes how many dummy cycles come before mem_ready. A faulty interval timer shifts the spacing between row-strobe falls by whole cycles from the first interval onward.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_ACT, ST_PRE} strobe_st_t;
  typedef enum logic [1:0] {PH_WAIT, PH_DUMMY, PH_RUN} phase_t;
endpackage

// File: rtl/dref_timer.sv
module dref_timer #(
  parameter int INT_STD = 3120,
  parameter int INT_LP  = 24960
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lp_sel,
  output logic tick
);
  localparam int MAXI = (INT_LP > INT_STD) ? INT_LP : INT_STD;
  localparam int CW   = $clog2(MAXI + 1);

  logic [CW-1:0] cnt_q, cnt_d, limit;

  assign limit = lp_sel ? CW'(INT_LP - 1) : CW'(INT_STD - 1);
  assign tick  = en && (cnt_q >= limit);

  always_comb begin
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dref_pending.sv
module dref_pending #(
  parameter int PEND_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic nz
);
  localparam int PW = $clog2(PEND_MAX + 1);
  localparam logic [PW-1:0] FULL = PW'(PEND_MAX);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    unique case ({inc, dec})
      2'b10:   cnt_d = (cnt_q == FULL) ? cnt_q : cnt_q + 1'b1;
      2'b01:   cnt_d = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign nz = (cnt_q != '0);
endmodule

// File: rtl/dref_strobe_fsm.sv
module dref_strobe_fsm
  import dref_pkg::*;
#(
  parameter int T_CSR = 1,
  parameter int T_RAS = 12,
  parameter int T_RP  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic ras_n,
  output logic cas_n
);
  localparam int MAXT = (T_RAS > T_RP) ? ((T_RAS > T_CSR) ? T_RAS : T_CSR)
                                       : ((T_RP > T_CSR) ? T_RP : T_CSR);
  localparam int TW = $clog2(MAXT + 1);
  localparam logic [TW-1:0] LAST_LEAD = TW'(T_CSR - 1);
  localparam logic [TW-1:0] LAST_ACT  = TW'(T_RAS - 1);
  localparam logic [TW-1:0] LAST_PRE  = TW'(T_RP - 1);

  strobe_st_t    st_q, st_d;
  logic [TW-1:0] t_q, t_d;
  logic          ras_d, cas_d;

  always_comb begin
    st_d = st_q;
    t_d  = t_q + 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        t_d = '0;
        if (start) st_d = ST_LEAD;
      end
      ST_LEAD: if (t_q == LAST_LEAD) begin st_d = ST_ACT;  t_d = '0; end
      ST_ACT:  if (t_q == LAST_ACT)  begin st_d = ST_PRE;  t_d = '0; end
      ST_PRE:  if (t_q == LAST_PRE)  begin st_d = ST_IDLE; t_d = '0; end
      default: begin st_d = ST_IDLE; t_d = '0; end
    endcase
    ras_d = (st_d != ST_ACT);
    cas_d = !((st_d == ST_LEAD) || (st_d == ST_ACT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      t_q   <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
    end else begin
      st_q  <= st_d;
      t_q   <= t_d;
      ras_n <= ras_d;
      cas_n <= cas_d;
    end
  end

  assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/dref_seq.sv
module dref_seq
  import dref_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int INIT_WAIT   = 40000,
  parameter int INIT_CYCLES = 8,
  parameter int INT_STD     = 3120,
  parameter int INT_LP      = 24960,
  parameter int PEND_MAX    = 8,
  parameter int T_CSR       = 1,
  parameter int T_RAS       = 12,
  parameter int T_RP        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp_sel,
  input  logic              ctrl_idle,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ref_req,
  output logic              ref_busy,
  output logic              mem_ready
);
  localparam int WW = $clog2(INIT_WAIT + 1);
  localparam int DW = $clog2(INIT_CYCLES + 1);
  localparam logic [WW-1:0] WAIT_LAST = WW'(INIT_WAIT - 1);

  phase_t        ph_q, ph_d;
  logic [WW-1:0] wait_q, wait_d;
  logic [DW-1:0] dum_q, dum_d;
  logic          busy, tick, pend_nz, start;

  assign start = !busy &&
                 (((ph_q == PH_DUMMY) && (dum_q != '0)) ||
                  ((ph_q == PH_RUN) && pend_nz && ctrl_idle));

  always_comb begin
    ph_d   = ph_q;
    wait_d = wait_q;
    dum_d  = dum_q;
    unique case (ph_q)
      PH_WAIT: begin
        if (wait_q == WAIT_LAST) ph_d = PH_DUMMY;
        else                     wait_d = wait_q + 1'b1;
      end
      PH_DUMMY: begin
        if (start) dum_d = dum_q - 1'b1;
        if ((dum_q == '0) && !busy) ph_d = PH_RUN;
      end
      default: ph_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_WAIT;
      wait_q <= '0;
      dum_q  <= DW'(INIT_CYCLES);
    end else begin
      ph_q   <= ph_d;
      wait_q <= wait_d;
      dum_q  <= dum_d;
    end
  end

  dref_timer #(.INT_STD(INT_STD), .INT_LP(INT_LP)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(ph_q == PH_RUN), .lp_sel(lp_sel), .tick(tick)
  );

  dref_pending #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk(clk), .rst_n(rst_n), .inc(tick), .dec(start && (ph_q == PH_RUN)), .nz(pend_nz)
  );

  dref_strobe_fsm #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .ras_n(ras_n), .cas_n(cas_n)
  );

  assign we_n      = 1'b1;
  assign oe_n      = 1'b1;
  assign addr_o    = '0;
  assign ref_req   = pend_nz;
  assign ref_busy  = busy;
  assign mem_ready = (ph_q == PH_RUN);
endmodule

// File: rtl/dref_seq_chk.sv
module dref_seq_chk #(
  parameter int T_RAS = 12
) (
  input logic clk,
  input logic rst_n,
  input logic ctrl_idle,
  input logic ras_n,
  input logic cas_n,
  input logic ref_busy,
  input logic mem_ready
);
  logic [15:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lo_cnt <= '0;
    else if (!ras_n) lo_cnt <= lo_cnt + 1'b1;
    else             lo_cnt <= '0;
  end

  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));

  a_r4_cas_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);

  a_r5_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_cnt == 16'(T_RAS)));

  a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready |=> mem_ready);

  a_r10_quiet_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_busy |-> (ras_n && cas_n));

  a_r8_grant_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ref_busy) && mem_ready) |-> $past(ctrl_idle));
endmodule

bind dref_seq dref_seq_chk #(.T_RAS(T_RAS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_idle(ctrl_idle), .ras_n(ras_n),
  .cas_n(cas_n), .ref_busy(ref_busy), .mem_ready(mem_ready)
);

// File: tb/tb_dref_seq.sv
module tb_dref_seq;
  localparam int INIT_WAIT = 200;
  localparam int INIT_CYC  = 8;
  localparam int I_STD     = 100;
  localparam int I_LP      = 300;
  localparam int PMAX      = 3;
  localparam int TCSR      = 1;
  localparam int TRAS      = 12;
  localparam int TRP       = 8;

  logic clk, rst_n, lp_sel, ctrl_idle;
  logic ras_n, cas_n, we_n, oe_n, ref_req, ref_busy, mem_ready;
  logic [9:0] addr_o;

  dref_seq #(.ADDR_W(10), .INIT_WAIT(INIT_WAIT), .INIT_CYCLES(INIT_CYC),
             .INT_STD(I_STD), .INT_LP(I_LP), .PEND_MAX(PMAX),
             .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)) dut (
    .clk(clk), .rst_n(rst_n), .lp_sel(lp_sel), .ctrl_idle(ctrl_idle),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .addr_o(addr_o),
    .ref_req(ref_req), .ref_busy(ref_busy), .mem_ready(mem_ready));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  integer n_chk = 0, n_bad = 0, cyc = 0;
  bit     done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input integer act, input integer exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // edge monitor
  logic   p_ras = 1'b1, p_cas = 1'b1, p_busy = 1'b0;
  integer lead_cnt = 0, low_cnt = 0, gap_cnt = 0;
  integer ras_falls = 0, last_fall = 0, intvl = 0, first_cas = -1;
  bit     cas_rose_in_low = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cas_n && p_cas) begin
        if (first_cas < 0) first_cas = cyc;
        check(ref_busy == 1'b1, "R10 busy at cas fall", ref_busy, 1);
        if (ras_falls > 0) check(gap_cnt >= TRP, "R5 precharge", gap_cnt, TRP);
      end
      if (!ras_n && p_ras) begin
        check(lead_cnt == TCSR, "R4 cas lead", lead_cnt, TCSR);
        check(we_n && oe_n && addr_o == 0, "R6 fixed lines", {we_n, oe_n}, 3);
        ras_falls++;
        intvl = cyc - last_fall;
        last_fall = cyc;
        cas_rose_in_low = 0;
      end
      if (!ras_n && cas_n) cas_rose_in_low = 1;
      if (ras_n && !p_ras) begin
        check(low_cnt == TRAS, "R5 ras width", low_cnt, TRAS);
        check(!cas_rose_in_low, "R4 cas held", cas_rose_in_low, 0);
      end
      if (!ref_busy && p_busy)
        check(ras_n && cas_n, "R10 strobes at busy end", {ras_n, cas_n}, 3);
      lead_cnt = (!cas_n && ras_n) ? lead_cnt + 1 : 0;
      low_cnt  = !ras_n ? low_cnt + 1 : 0;
      gap_cnt  = (ras_n && cas_n) ? gap_cnt + 1 : ((!ras_n) ? 0 : gap_cnt);
      p_ras = ras_n; p_cas = cas_n; p_busy = ref_busy;
    end
  end

  task automatic t_reset();
    rst_n = 1'b0; lp_sel = 1'b0; ctrl_idle = 1'b0;
    repeat (3) @(negedge clk);
    check(ras_n && cas_n && we_n && oe_n, "R1 strobes in reset", {ras_n, cas_n, we_n, oe_n}, 15);
    check(addr_o == 0, "R1 addr in reset", addr_o, 0);
    check(!ref_req && !ref_busy && !mem_ready, "R1 flags in reset",
          {ref_req, ref_busy, mem_ready}, 0);
  endtask

  task automatic t_init();
    integer rel;
    rst_n = 1'b1;
    rel = cyc;
    @(negedge clk);
    check(ras_n && cas_n && !mem_ready, "R1 after release", {ras_n, cas_n, mem_ready}, 6);
    while (!mem_ready) @(negedge clk);
    check(first_cas - rel >= INIT_WAIT, "R2 start delay min", first_cas - rel, INIT_WAIT);
    check(first_cas - rel <= INIT_WAIT + 3, "R2 start delay max", first_cas - rel, INIT_WAIT + 3);
    check(ras_falls == INIT_CYC, "R3 dummy count", ras_falls, INIT_CYC);
  endtask

  task automatic wait_falls(input integer k);
    integer n0;
    n0 = ras_falls;
    while (ras_falls < n0 + k) @(negedge clk);
  endtask

  task automatic t_interval_std();
    ctrl_idle = 1'b1; lp_sel = 1'b0;
    wait_falls(2);
    for (int i = 0; i < 3; i++) begin
      wait_falls(1);
      check(intvl == I_STD, "R7 std interval", intvl, I_STD);
    end
  endtask

  task automatic t_interval_lp();
    lp_sel = 1'b1;
    wait_falls(2);
    for (int i = 0; i < 2; i++) begin
      wait_falls(1);
      check(intvl == I_LP, "R7 lp interval", intvl, I_LP);
    end
  endtask

  task automatic t_defer();
    integer n0;
    lp_sel = 1'b0;
    wait_falls(1);
    @(negedge clk);
    ctrl_idle = 1'b0;
    n0 = ras_falls;
    repeat (250) @(negedge clk);
    check(ras_falls == n0, "R8 no refresh while busy ctrl", ras_falls, n0);
    check(ref_req == 1'b1, "R8 request held", ref_req, 1);
    ctrl_idle = 1'b1;
    repeat (5) @(negedge clk);
    check(ras_falls > n0, "R8 refresh after idle", ras_falls, n0 + 1);
  endtask

  task automatic t_saturate();
    integer n0;
    lp_sel = 1'b1; ctrl_idle = 1'b1;
    while (ref_req || ref_busy) @(negedge clk);
    ctrl_idle = 1'b0;
    while (!ref_req) @(negedge clk);
    repeat (4 * I_LP) @(negedge clk);
    n0 = ras_falls;
    ctrl_idle = 1'b1;
    repeat (90) @(negedge clk);
    check(ras_falls - n0 == PMAX, "R9 saturated burst", ras_falls - n0, PMAX);
    check(ref_req == 1'b0, "R9 pending drained", ref_req, 0);
    check(mem_ready == 1'b1, "R3 ready still high", mem_ready, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog R1-R10 run", cyc, 100000);
    finish_run();
  end

  initial begin
    t_reset();
    t_init();
    t_interval_std();
    t_interval_lp();
    t_defer();
    t_saturate();
    finish_run();
  end
endmodule